// File: doc/BRIEF.md
# Multi-Symbol Interval Locator for an Adaptive Range Decoder

This block performs the symbol-search half of one step of a multi-symbol arithmetic range decoder. It takes the current 16-bit range, the upper 16 bits of the decoder window and a set of N inverse cumulative probability entries, where N is between 2 and 16. It returns the index of the decoded symbol together with the two interval bounds that enclose it. A later stage uses those bounds to form the new range and to subtract from the window. Probability adaptation and renormalization belong to other stages.

All boundary values are formed in parallel. Each probability entry is reduced to its upper 10 bits. It is scaled by the range with its low byte and top bit removed. A minimum-probability offset is then added, and that offset grows by 4 for every symbol that remains above the lane. The window is compared against every boundary at once. The lowest lane whose boundary does not exceed the window gives the symbol. The comparison and selection are combinational, and the result is registered. An accepted request produces a one-cycle result pulse on the next clock.

Top module: `cdf_symbol_decoder`

## Requirements
- R1: While reset is asserted, `outValid`, `outSym`, `outUpper` and `outLower` are all zero and `inReady` is low. `inReady` is high from the first clock edge after reset is released.
- R2: A request is accepted on a clock edge where `inValid` and `inReady` are both high. `outValid` is high during the cycle after each accepted request and is low after any edge with no accepted request.
- R3: The low 6 bits of every probability entry are ignored. Entry i is used as `cdf_i & 0xFFC0`, and entry i occupies bits [16*i+15:16*i] of `cdfFlat`.
- R4: Only range bits 14..8 take part in the boundary computation. Other bits of `rangeIn` affect only the upper bound of symbol 0.
- R5: For lane i < N-1, the boundary is `split_i = ((cdf_i & 0xFFC0) * (rangeIn & 0x7F00)) >> 15` plus `4*(N-1-i)`. N is the value of `symCount`.
- R6: `outSym` is the smallest lane index i for which `winIn >= split_i`.
- R7: `outLower` equals `split_outSym`. `outUpper` equals `rangeIn` when `outSym` is 0, and `split_(outSym-1)` otherwise.
- R8: The boundary of the last symbol, lane N-1, is 0. So `outSym` never exceeds N-1, and a window of 0 always decodes symbol N-1 with `outLower` equal to 0.
- R9: Probability entries at lanes N-1 and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| rangeIn | input | 16 | Current decoder range |
| winIn | input | 16 | Upper 16 bits of the decoder window |
| symCount | input | 5 | Number of symbols N (2..16) |
| cdfFlat | input | 256 | Inverse cumulative probabilities, 16 bits per lane, lane 0 in the low bits |
| outValid | output | 1 | One-cycle result strobe |
| outSym | output | 4 | Decoded symbol index |
| outUpper | output | 16 | Upper bound u of the chosen interval |
| outLower | output | 16 | Lower bound v of the chosen interval |

## Verification
On every cycle the assertions check the following:
- The result pulse follows exactly the accepted requests.
- The decoded index stays below the symbol count.
- The window lies at or above the lower bound.
- For a nonzero symbol, the window lies strictly below the upper bound.

The exact arithmetic can only be shown by the scenarios, which compare each result against an independent model. That arithmetic covers the masking of probabilities and range, the offset ladder, the choice of the lowest qualifying lane and the independence from unused lanes. The scenarios cover several symbol counts, back-to-back and spaced requests, zero and full-scale windows, and perturbed low bits.

// File: rtl/cdf_dec_pkg.sv
package cdf_dec_pkg;
  localparam int unsigned PROB_W = 16;
  localparam logic [15:0] PROB_MASK = 16'hFFC0;
  localparam logic [15:0] RANGE_MASK = 16'h7F00;
  localparam int unsigned MIN_PROB_STEP = 4;

  typedef struct packed {
    logic capture;
    logic idle;
  } ctrlStrobe_t;
endpackage

// File: rtl/cdf_split_lane.sv
module cdf_split_lane
  import cdf_dec_pkg::*;
#(
  parameter int unsigned IDX = 0,
  parameter int unsigned CNT_W = 5
) (
  input  logic [PROB_W-1:0] cdfEntry,
  input  logic [PROB_W-1:0] rngMasked,
  input  logic [CNT_W-1:0]  symCount,
  output logic [PROB_W-1:0] split
);
  localparam int unsigned PROD_W = 2 * PROB_W;

  logic [PROD_W-1:0] product;
  logic [PROB_W-1:0] scaled;
  logic [PROB_W-1:0] offset;
  logic              active;

  // lane carries a real boundary only below the last symbol
  assign active  = (32'(IDX) + 32'd1) < 32'(symCount);
  assign product = {{PROB_W{1'b0}}, cdfEntry & PROB_MASK} * {{PROB_W{1'b0}}, rngMasked};
  assign scaled  = product[PROD_W-2 -: PROB_W];

  always_comb begin
    offset = '0;
    if (active) begin
      offset = PROB_W'((32'(symCount) - 32'(IDX) - 32'd1) * MIN_PROB_STEP);
    end
  end

  assign split = active ? (scaled + offset) : '0;
endmodule

// File: rtl/cdf_dec_ctrl.sv
module cdf_dec_ctrl
  import cdf_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output ctrlStrobe_t strobe
);
  logic readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign inReady        = readyQ;
  assign strobe.capture = inValid && readyQ;
  assign strobe.idle    = !(inValid && readyQ);
endmodule

// File: rtl/cdf_dec_datapath.sv
module cdf_dec_datapath
  import cdf_dec_pkg::*;
#(
  parameter int unsigned LANES = 16,
  localparam int unsigned SYM_W = $clog2(LANES),
  localparam int unsigned CNT_W = SYM_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [PROB_W-1:0]       rangeIn,
  input  logic [PROB_W-1:0]       winIn,
  input  logic [CNT_W-1:0]        symCount,
  input  logic [LANES*PROB_W-1:0] cdfFlat,
  output logic                    outValid,
  output logic [SYM_W-1:0]        outSym,
  output logic [PROB_W-1:0]       outUpper,
  output logic [PROB_W-1:0]       outLower
);
  logic [PROB_W-1:0] rngMasked;
  logic [PROB_W-1:0] splits [LANES];
  logic [LANES-1:0]  hitMask;
  logic [SYM_W-1:0]  symSel;
  logic [PROB_W-1:0] upperSel;
  logic [PROB_W-1:0] lowerSel;

  assign rngMasked = rangeIn & RANGE_MASK;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cdf_split_lane #(.IDX(g), .CNT_W(CNT_W)) u_lane (
      .cdfEntry (cdfFlat[g*PROB_W +: PROB_W]),
      .rngMasked(rngMasked),
      .symCount (symCount),
      .split    (splits[g])
    );
    assign hitMask[g] = winIn >= splits[g];
  end

  // lowest flagged lane wins
  always_comb begin
    symSel = SYM_W'(LANES - 1);
    for (int i = LANES - 1; i >= 0; i--) begin
      if (hitMask[i]) symSel = SYM_W'(i);
    end
  end

  always_comb begin
    lowerSel = splits[symSel];
    if (symSel == '0) upperSel = rangeIn;
    else              upperSel = splits[symSel - SYM_W'(1)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSym   <= '0;
      outUpper <= '0;
      outLower <= '0;
    end else if (strobe.capture) begin
      outValid <= 1'b1;
      outSym   <= symSel;
      outUpper <= upperSel;
      outLower <= lowerSel;
    end else if (strobe.idle) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/cdf_symbol_decoder.sv
module cdf_symbol_decoder
  import cdf_dec_pkg::*;
#(
  parameter int unsigned LANES = 16,
  localparam int unsigned SYM_W = $clog2(LANES),
  localparam int unsigned CNT_W = SYM_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [PROB_W-1:0]       rangeIn,
  input  logic [PROB_W-1:0]       winIn,
  input  logic [CNT_W-1:0]        symCount,
  input  logic [LANES*PROB_W-1:0] cdfFlat,
  output logic                    outValid,
  output logic [SYM_W-1:0]        outSym,
  output logic [PROB_W-1:0]       outUpper,
  output logic [PROB_W-1:0]       outLower
);
  ctrlStrobe_t strobe;

  cdf_dec_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inReady(inReady),
    .strobe (strobe)
  );

  cdf_dec_datapath #(.LANES(LANES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rangeIn (rangeIn),
    .winIn   (winIn),
    .symCount(symCount),
    .cdfFlat (cdfFlat),
    .outValid(outValid),
    .outSym  (outSym),
    .outUpper(outUpper),
    .outLower(outLower)
  );
endmodule

// File: rtl/cdf_symbol_decoder_chk.sv
module cdf_symbol_decoder_chk #(
  parameter int unsigned LANES = 16,
  localparam int unsigned SYM_W = $clog2(LANES),
  localparam int unsigned CNT_W = SYM_W + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic [15:0]          rangeIn,
  input logic [15:0]          winIn,
  input logic [CNT_W-1:0]     symCount,
  input logic [LANES*16-1:0]  cdfFlat,
  input logic                 outValid,
  input logic [SYM_W-1:0]     outSym,
  input logic [15:0]          outUpper,
  input logic [15:0]          outLower
);
  logic pastRun;
  always_ff @(posedge clk) pastRun <= rstN;

  a_r2_pulse_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  a_r2_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !(inValid && inReady)) |=> !outValid);

  a_r8_sym_below_count: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (32'(outSym) < 32'($past(symCount))));

  a_r6_window_at_or_above_lower: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outLower <= $past(winIn)));

  a_r6_window_below_upper: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outSym == '0 || $past(winIn) < outUpper));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outValid && !inReady));
endmodule

bind cdf_symbol_decoder cdf_symbol_decoder_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/cdf_symbol_decoder_tb.sv
module cdf_symbol_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] rangeIn = '0;
  logic [15:0] winIn = '0;
  logic [4:0]  symCount = 5'd2;
  logic [LANES*16-1:0] cdfFlat = '0;
  logic        outValid;
  logic [3:0]  outSym;
  logic [15:0] outUpper;
  logic [15:0] outLower;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int sym;
    int upper;
    int lower;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cdf_symbol_decoder #(.LANES(LANES)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .rangeIn(rangeIn), .winIn(winIn), .symCount(symCount), .cdfFlat(cdfFlat),
    .outValid(outValid), .outSym(outSym), .outUpper(outUpper), .outLower(outLower)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model of the requirements
  function automatic expItem_t model(input int n, input int rng, input int win,
                                     input int cdf[LANES], input string tag);
    int sp[LANES];
    expItem_t e;
    for (int i = 0; i < LANES; i++) begin
      if (i < n - 1)
        sp[i] = (((cdf[i] & 'hFFC0) * (rng & 'h7F00)) >>> 15) + 4 * (n - 1 - i);
      else
        sp[i] = 0;
    end
    e.sym = n - 1;
    for (int i = n - 1; i >= 0; i--) if (win >= sp[i]) e.sym = i;
    e.lower = sp[e.sym];
    e.upper = (e.sym == 0) ? rng : sp[e.sym - 1];
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input int n, input int rng, input int win, input int cdf[LANES],
                      input string tag, input bit gap);
    while (!inReady) @(negedge clk);
    symCount = 5'(n);
    rangeIn  = 16'(rng);
    winIn    = 16'(win);
    for (int i = 0; i < LANES; i++) cdfFlat[i*16 +: 16] = 16'(cdf[i]);
    inValid  = 1'b1;
    expQ.push_back(model(n, rng, win, cdf, tag));
    @(negedge clk);
    if (gap) begin
      inValid = 1'b0;
      @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected pulse", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " sym"}, int'(outSym), e.sym);
        check({e.tag, " upper"}, int'(outUpper), e.upper);
        check({e.tag, " lower"}, int'(outLower), e.lower);
      end
    end
  end

  task automatic mkCdf(input int n, output int cdf[LANES]);
    int prev;
    prev = 32768;
    for (int i = 0; i < LANES; i++) begin
      if (i < n - 1) begin
        int room;
        room = prev / (n - i);
        prev = prev - 1 - int'($urandom_range(0, room > 1 ? room : 1));
        if (prev < 0) prev = 0;
        cdf[i] = prev;
      end else begin
        cdf[i] = 0;
      end
    end
  endtask

  initial begin
    int cdf[LANES];
    int alt[LANES];
    int rng;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outSym in reset", int'(outSym), 0);
    check("R1 outUpper in reset", int'(outUpper), 0);
    check("R1 outLower in reset", int'(outLower), 0);
    check("R1 inReady in reset", int'(inReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inReady after reset", int'(inReady), 1);

    // R5 R6 R7 fixed pattern, N=4
    cdf = '{24576, 16384, 8192, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(4, 'hC000, 'hFFFF, cdf, "R6 top window", 1'b1);
    send(4, 'hC000, 'h5000, cdf, "R5 mid window", 1'b1);
    send(4, 'hC000, 'h2000, cdf, "R7 interval", 1'b1);
    send(4, 'hC000, 0, cdf, "R8 zero window", 1'b1);

    // R3 low probability bits ignored
    alt = cdf;
    for (int i = 0; i < 3; i++) alt[i] = cdf[i] | 'h3F;
    send(4, 'hC000, 'h5000, alt, "R3 low bits set", 1'b1);
    // R4 range low bits ignored for nonzero symbol
    send(4, 'hC0FF, 'h2000, cdf, "R4 range low bits", 1'b1);
    send(4, 'h40FF, 'h2000, cdf, "R4 range top bit", 1'b1);
    // R9 unused lanes filled with garbage
    alt = cdf;
    for (int i = 3; i < LANES; i++) alt[i] = 'hFFFF;
    send(4, 'hC000, 'h1000, alt, "R9 unused lanes", 1'b1);

    // R8 with N=2 and N=16 zero windows
    mkCdf(2, cdf);
    send(2, 'h8000, 0, cdf, "R8 n2 zero", 1'b1);
    mkCdf(16, cdf);
    send(16, 'hFFFF, 0, cdf, "R8 n16 zero", 1'b1);

    // R2 back-to-back random traffic across symbol counts
    for (int k = 0; k < 200; k++) begin
      int n;
      n = int'($urandom_range(2, 16));
      mkCdf(n, cdf);
      for (int i = n - 1; i < LANES; i++) cdf[i] = int'($urandom_range(0, 'hFFFF));
      rng = int'($urandom_range('h8000, 'hFFFF));
      send(n, rng, int'($urandom_range(0, rng - 1)), cdf, "R2 stream", (k % 5) == 0);
    end
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 all results delivered", expQ.size(), 0);
    check("R2 idle after traffic", int'(outValid), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule